// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge turns a word-addressed alias window into bit-granular accesses on a backing memory region. The alias window is 32 MB wide. Each 32-bit alias word stands for one bit of backing memory, so software can test, set or clear a single bit with one load or store and no masking of its own. An alias read fetches the data that holds the bit and returns only that bit. An alias write fetches the same data, changes the one bit, and writes the data back.

The alias side is a slave port with a valid/ready request channel and a valid/ready response channel. The backing side is a master port with the same pair of channels. The base of the backing region is a parameter. The bridge works on one request at a time. A read-modify-write is complete, with its write response, before the bridge accepts the next alias request.

Top module: `bitband_bridge`

## Requirements
- R1: The backing byte address is `BASE_ADDR | (alias_addr[24:0] >> 5)`, before the alignment of R2. Alias address bits 31 to 25 have no effect.
- R2: The backing address is rounded down to a multiple of the access size. Its low 0, 1 or 2 bits are cleared for size code 0, 1 or 2.
- R3: Size code 0, 1 or 2 means 1, 2 or 4 bytes, and the backing access carries the same size code. Size code 3 ends the alias access with an error response and data 0, and no backing access is issued.
- R4: The bit index inside the fetched data is `alias_addr[6:2]` masked to 3, 4 or 5 bits for size code 0, 1 or 2. The fetched data is little-endian and right-justified: byte k of the access sits on bits [8k+7:8k] of the data bus.
- R5: A successful read returns the indexed bit in response bit 0, with every other response bit 0 and the error flag clear.
- R6: A write first reads the backing data. It then writes back the same size, with the indexed bit set to write-data bit 0 and all other bits inside the access size unchanged. Write-data bits 31 to 1 have no effect.
- R7: If the backing read responds with an error, the alias access ends with an error and data 0, and no backing write is issued.
- R8: The error flag of the backing write response is passed to the alias response of that write, with data 0.
- R9: From the moment an alias request is accepted until its response has been taken, `s_req_ready` stays low. At most one backing request is outstanding at any time.
- R10: While reset is held, no request or response is offered on either port, `m_rsp_ready` is low and `s_req_ready` is high.
- R11: A request offered on the backing port, and a response offered on the alias port, hold their valid and their payload until they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_req_valid | input | 1 | Alias request offered |
| s_req_ready | output | 1 | Bridge idle and taking an alias request |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_addr | input | ADDR_W | Alias byte address; only bits [24:0] are used |
| s_req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = not allowed |
| s_req_wdata | input | DATA_W | Write data; bit 0 is the new bit value |
| s_rsp_valid | output | 1 | Alias response offered |
| s_rsp_ready | input | 1 | Alias response taken |
| s_rsp_rdata | output | DATA_W | Read result in bit 0; zero for writes and errors |
| s_rsp_err | output | 1 | Alias access failed |
| m_req_valid | output | 1 | Backing request offered |
| m_req_ready | input | 1 | Backing request taken |
| m_req_write | output | 1 | Backing write (1) or read (0) |
| m_req_addr | output | ADDR_W | Aligned backing byte address |
| m_req_size | output | 2 | Backing size code, equal to the alias size code |
| m_req_wdata | output | DATA_W | Merged data for the backing write |
| m_rsp_valid | input | 1 | Backing response offered |
| m_rsp_ready | output | 1 | Bridge waiting for a backing response |
| m_rsp_rdata | input | DATA_W | Backing read data, right-justified |
| m_rsp_err | input | 1 | Backing access failed |

## Verification
Reads are issued with every size code at offsets that hit the lowest and highest bit of an access and bits in the upper bytes. These tell a wrong bit index, a wrong lane order and a missing alignment apart. Writes with write-data bit 0 set and clear, and with noise in the upper write bits, show whether neighbouring bits survive the merge. Writing all 32 bits of one word and reading them back checks that chain end to end. Backing read errors, backing write errors, size code 3, the last word of the window and alias addresses with junk in the upper bits each isolate one path. Backing latency and response back-pressure probe the single-outstanding rule and the payload hold.

// File: rtl/bb_pkg.sv
package bb_pkg;

   localparam int SIZE_W = 2;
   localparam int WORD_SHIFT = 2;
   localparam int BYTE_SHIFT = 3;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_REQ  = 3'd1,
      ST_RD_WAIT = 3'd2,
      ST_WR_REQ  = 3'd3,
      ST_WR_WAIT = 3'd4,
      ST_RESP    = 3'd5
   } bb_state_e;

endpackage

// File: rtl/bb_addr_xlate.sv
module bb_addr_xlate
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WIN_BITS = 25,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
   input  logic [ADDR_W-1:0] alias_addr,
   input  logic [SIZE_W-1:0] size_code,
   output logic [ADDR_W-1:0] back_addr,
   output logic [$clog2(DATA_W)-1:0] bit_pos,
   output logic size_ok
);
   localparam int BITPOS_W = $clog2(DATA_W);
   localparam int MAX_CODE = $clog2(DATA_W / 8);
   localparam int ALIAS_SHIFT = WORD_SHIFT + BYTE_SHIFT;

   logic [WIN_BITS-1:0] win_off;
   logic [ADDR_W-1:0] byte_idx;
   logic [ADDR_W-1:0] align_mask;
   logic [BITPOS_W-1:0] raw_pos;
   logic [BITPOS_W-1:0] pos_mask;

   assign win_off = alias_addr[WIN_BITS-1:0];
   assign byte_idx = ADDR_W'(win_off >> ALIAS_SHIFT);
   assign size_ok = (int'(size_code) <= MAX_CODE);
   assign align_mask = ~((ADDR_W'(1) << size_code) - ADDR_W'(1));
   assign back_addr = (BASE_ADDR | byte_idx) & align_mask;

   assign raw_pos = alias_addr[BITPOS_W+WORD_SHIFT-1:WORD_SHIFT];
   assign pos_mask = BITPOS_W'((32'd8 << size_code) - 32'd1);
   assign bit_pos = raw_pos & pos_mask;

endmodule

// File: rtl/bb_bit_ops.sv
module bb_bit_ops
   import bb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] fetched,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [$clog2(DATA_W)-1:0] bit_pos,
   input  logic new_bit,
   output logic sel_bit,
   output logic [DATA_W-1:0] merged
);
   localparam int BITPOS_W = $clog2(DATA_W);
   localparam int MAX_CODE = $clog2(DATA_W / 8);

   logic [DATA_W-1:0] lane_keep;

   always_comb begin
      lane_keep = '1;
      for (int c = 0; c < MAX_CODE; c++) begin
         if (int'(size_code) == c) begin
            lane_keep = (DATA_W'(1) << (8 << c)) - DATA_W'(1);
         end
      end
   end

   assign sel_bit = fetched[bit_pos];

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane_bit
      assign merged[i] = (bit_pos == BITPOS_W'(i)) ? new_bit
                                                   : (fetched[i] & lane_keep[i]);
   end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_req_valid,
   output logic s_req_ready,
   input  logic s_req_write,
   input  logic s_req_bit,
   input  logic [SIZE_W-1:0] s_req_size,
   input  logic [ADDR_W-1:0] xl_addr,
   input  logic [$clog2(DATA_W)-1:0] xl_pos,
   input  logic xl_size_ok,
   output logic s_rsp_valid,
   input  logic s_rsp_ready,
   output logic [DATA_W-1:0] s_rsp_rdata,
   output logic s_rsp_err,
   output logic m_req_valid,
   input  logic m_req_ready,
   output logic m_req_write,
   output logic [ADDR_W-1:0] m_req_addr,
   output logic [SIZE_W-1:0] m_req_size,
   output logic [DATA_W-1:0] m_req_wdata,
   input  logic m_rsp_valid,
   output logic m_rsp_ready,
   input  logic m_rsp_err,
   input  logic ops_bit,
   input  logic [DATA_W-1:0] ops_merged,
   output logic [SIZE_W-1:0] op_size,
   output logic [$clog2(DATA_W)-1:0] op_pos,
   output logic op_bit
);
   localparam int BITPOS_W = $clog2(DATA_W);

   bb_state_e state;
   logic op_write;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rsp_data;
   logic rsp_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_write <= 1'b0;
         op_addr  <= '0;
         op_size  <= '0;
         op_pos   <= '0;
         op_bit   <= 1'b0;
         wr_data  <= '0;
         rsp_data <= '0;
         rsp_err  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (s_req_valid) begin
                  op_write <= s_req_write;
                  op_addr  <= xl_addr;
                  op_size  <= s_req_size;
                  op_pos   <= xl_pos;
                  op_bit   <= s_req_bit;
                  if (xl_size_ok) begin
                     state <= ST_RD_REQ;
                  end else begin
                     rsp_err  <= 1'b1;
                     rsp_data <= '0;
                     state    <= ST_RESP;
                  end
               end
            end
            ST_RD_REQ: begin
               if (m_req_ready) state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (m_rsp_valid) begin
                  if (m_rsp_err) begin
                     rsp_err  <= 1'b1;
                     rsp_data <= '0;
                     state    <= ST_RESP;
                  end else if (op_write) begin
                     wr_data <= ops_merged;
                     state   <= ST_WR_REQ;
                  end else begin
                     rsp_err  <= 1'b0;
                     rsp_data <= DATA_W'(ops_bit);
                     state    <= ST_RESP;
                  end
               end
            end
            ST_WR_REQ: begin
               if (m_req_ready) state <= ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
               if (m_rsp_valid) begin
                  rsp_err  <= m_rsp_err;
                  rsp_data <= '0;
                  state    <= ST_RESP;
               end
            end
            ST_RESP: begin
               if (s_rsp_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign s_req_ready = (state == ST_IDLE);
   assign m_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign m_req_write = (state == ST_WR_REQ);
   assign m_req_addr  = op_addr;
   assign m_req_size  = op_size;
   assign m_req_wdata = wr_data;
   assign m_rsp_ready = (state == ST_RD_WAIT) || (state == ST_WR_WAIT);
   assign s_rsp_valid = (state == ST_RESP);
   assign s_rsp_rdata = rsp_data;
   assign s_rsp_err   = rsp_err;

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req_valid && s_req_ready) |=> !s_req_ready);

   assert_busy_while_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_rsp_valid |-> (!s_req_ready && !m_req_valid));

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_valid && !m_req_ready) |=>
         (m_req_valid && $stable(m_req_addr) && $stable(m_req_write)
          && $stable(m_req_size) && $stable(m_req_wdata)));

   assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rsp_valid && !s_rsp_ready) |=>
         (s_rsp_valid && $stable(s_rsp_rdata) && $stable(s_rsp_err)));

   assert_rd_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rsp_valid && m_rsp_ready && m_rsp_err && !op_write) |=>
         (s_rsp_valid && s_rsp_err));

   assert_rmw_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_WAIT && m_rsp_valid && m_rsp_err) |=> !m_req_valid);

   assert_wr_err_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR_WAIT && m_rsp_valid) |=> (s_rsp_err == $past(m_rsp_err)));

   assert_rd_bit0_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      s_rsp_valid |-> (s_rsp_rdata[DATA_W-1:1] == '0));

   assert_bad_size_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req_valid && s_req_ready && !xl_size_ok) |=> (s_rsp_valid && s_rsp_err));

   logic unused_pos;
   assign unused_pos = ^{BITPOS_W'(0)};

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WIN_BITS = 25,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_req_valid,
   output logic s_req_ready,
   input  logic s_req_write,
   input  logic [ADDR_W-1:0] s_req_addr,
   input  logic [1:0] s_req_size,
   input  logic [DATA_W-1:0] s_req_wdata,
   output logic s_rsp_valid,
   input  logic s_rsp_ready,
   output logic [DATA_W-1:0] s_rsp_rdata,
   output logic s_rsp_err,
   output logic m_req_valid,
   input  logic m_req_ready,
   output logic m_req_write,
   output logic [ADDR_W-1:0] m_req_addr,
   output logic [1:0] m_req_size,
   output logic [DATA_W-1:0] m_req_wdata,
   input  logic m_rsp_valid,
   output logic m_rsp_ready,
   input  logic [DATA_W-1:0] m_rsp_rdata,
   input  logic m_rsp_err
);
   localparam int BITPOS_W = $clog2(DATA_W);

   if (DATA_W < 8 || DATA_W > 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("bitband_bridge: DATA_W must be a power of two from 8 to 64");
   end
   if (WIN_BITS <= BITPOS_W + WORD_SHIFT || WIN_BITS > ADDR_W) begin : g_bad_win
      $error("bitband_bridge: WIN_BITS out of range");
   end
   if (SIZE_W != 2) begin : g_bad_size_w
      $error("bitband_bridge: size code must be two bits wide");
   end

   logic [ADDR_W-1:0] xl_addr;
   logic [BITPOS_W-1:0] xl_pos;
   logic xl_size_ok;
   logic [SIZE_W-1:0] op_size;
   logic [BITPOS_W-1:0] op_pos;
   logic op_bit;
   logic ops_bit;
   logic [DATA_W-1:0] ops_merged;

   bb_addr_xlate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
   ) u_xlate (
      .alias_addr(s_req_addr),
      .size_code (s_req_size),
      .back_addr (xl_addr),
      .bit_pos   (xl_pos),
      .size_ok   (xl_size_ok)
   );

   bb_bit_ops #(.DATA_W(DATA_W)) u_ops (
      .fetched  (m_rsp_rdata),
      .size_code(op_size),
      .bit_pos  (op_pos),
      .new_bit  (op_bit),
      .sel_bit  (ops_bit),
      .merged   (ops_merged)
   );

   bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_req_valid(s_req_valid),
      .s_req_ready(s_req_ready),
      .s_req_write(s_req_write),
      .s_req_bit  (s_req_wdata[0]),
      .s_req_size (s_req_size),
      .xl_addr    (xl_addr),
      .xl_pos     (xl_pos),
      .xl_size_ok (xl_size_ok),
      .s_rsp_valid(s_rsp_valid),
      .s_rsp_ready(s_rsp_ready),
      .s_rsp_rdata(s_rsp_rdata),
      .s_rsp_err  (s_rsp_err),
      .m_req_valid(m_req_valid),
      .m_req_ready(m_req_ready),
      .m_req_write(m_req_write),
      .m_req_addr (m_req_addr),
      .m_req_size (m_req_size),
      .m_req_wdata(m_req_wdata),
      .m_rsp_valid(m_rsp_valid),
      .m_rsp_ready(m_rsp_ready),
      .m_rsp_err  (m_rsp_err),
      .ops_bit    (ops_bit),
      .ops_merged (ops_merged),
      .op_size    (op_size),
      .op_pos     (op_pos),
      .op_bit     (op_bit)
   );

   assert_backing_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_valid |-> ((m_req_addr & ((ADDR_W'(1) << m_req_size) - ADDR_W'(1))) == '0));

   assert_backing_in_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_valid |-> ((m_req_addr & BASE_ADDR) == BASE_ADDR));

   assert_one_side_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({s_req_ready, m_req_valid, m_rsp_ready, s_rsp_valid}));

endmodule

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;

   localparam logic [31:0] BASE = 32'h2000_0000;
   localparam logic [31:0] ALIAS = 32'h2200_0000;
   localparam logic [31:0] NO_ERR = 32'hFFFF_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_req_valid = 1'b0;
   logic s_req_ready;
   logic s_req_write = 1'b0;
   logic [31:0] s_req_addr = '0;
   logic [1:0] s_req_size = '0;
   logic [31:0] s_req_wdata = '0;
   logic s_rsp_valid;
   logic s_rsp_ready = 1'b0;
   logic [31:0] s_rsp_rdata;
   logic s_rsp_err;
   logic m_req_valid;
   logic m_req_ready = 1'b0;
   logic m_req_write;
   logic [31:0] m_req_addr;
   logic [1:0] m_req_size;
   logic [31:0] m_req_wdata;
   logic m_rsp_valid = 1'b0;
   logic m_rsp_ready;
   logic [31:0] m_rsp_rdata = '0;
   logic m_rsp_err = 1'b0;

   always #10 clk = ~clk;

   bitband_bridge #(.BASE_ADDR(BASE)) i_bitband_bridge (
      .clk(clk), .rst_n(rst_n),
      .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
      .s_req_addr(s_req_addr), .s_req_size(s_req_size), .s_req_wdata(s_req_wdata),
      .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready), .s_rsp_rdata(s_rsp_rdata),
      .s_rsp_err(s_rsp_err),
      .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
      .m_req_addr(m_req_addr), .m_req_size(m_req_size), .m_req_wdata(m_req_wdata),
      .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready), .m_rsp_rdata(m_rsp_rdata),
      .m_rsp_err(m_rsp_err)
   );

   int n_checks = 0;
   int n_fails = 0;
   bit finished = 1'b0;

   logic [7:0] mem [int unsigned];
   int lat = 0;
   int rsp_hold = 0;
   logic [31:0] rd_err_addr = NO_ERR;
   logic [31:0] wr_err_addr = NO_ERR;
   int rd_cnt, wr_cnt;
   logic [31:0] rd_addr_log, wr_addr_log, wr_data_log;
   logic [1:0] rd_size_log, wr_size_log;

   function automatic logic [7:0] rd_byte(int unsigned a);
      if (mem.exists(a)) return mem[a];
      return 8'((a * 37) + 11);
   endfunction

   function automatic logic [31:0] fetch(logic [31:0] a, logic [1:0] sz);
      logic [31:0] v = '0;
      for (int b = 0; b < (1 << sz); b++) v |= 32'(rd_byte(a + 32'(b))) << (8 * b);
      return v;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // Backing memory responder
   initial begin
      logic q_wr;
      logic [31:0] q_addr, q_wdata, data;
      logic [1:0] q_size;
      logic err;
      forever begin
         @(negedge clk);
         if (m_req_valid && rst_n) begin
            repeat (lat) @(negedge clk);
            m_req_ready = 1'b1;
            q_wr = m_req_write; q_addr = m_req_addr;
            q_size = m_req_size; q_wdata = m_req_wdata;
            @(negedge clk);
            m_req_ready = 1'b0;
            if (!q_wr) begin
               rd_cnt++; rd_addr_log = q_addr; rd_size_log = q_size;
               err = (q_addr == rd_err_addr);
               data = err ? 32'hA5A5_A5A5 : fetch(q_addr, q_size);
            end else begin
               wr_cnt++; wr_addr_log = q_addr; wr_size_log = q_size; wr_data_log = q_wdata;
               err = (q_addr == wr_err_addr);
               if (!err)
                  for (int b = 0; b < (1 << q_size); b++)
                     mem[q_addr + 32'(b)] = q_wdata[8*b +: 8];
               data = '0;
            end
            m_rsp_valid = 1'b1; m_rsp_rdata = data; m_rsp_err = err;
            while (!m_rsp_ready) @(negedge clk);
            @(negedge clk);
            m_rsp_valid = 1'b0; m_rsp_rdata = '0; m_rsp_err = 1'b0;
         end
      end
   end

   // One alias access, checked against the behavioural model
   task automatic access(bit wr, logic [31:0] addr, logic [1:0] sz, logic [31:0] wd, string req);
      logic [31:0] ba, v, exp_rdata, exp_wdata;
      int bp, guard;
      bit ok_sz, rderr, exp_err, busy_bad;
      int exp_rd, exp_wr;
      ok_sz = (sz != 2'd3);
      ba = BASE | ((addr & 32'h01FF_FFFF) >> 5);
      if (ok_sz) ba &= ~((32'd1 << sz) - 32'd1);
      bp = int'((addr >> 2) & ((32'd8 << sz) - 32'd1));
      v = ok_sz ? fetch(ba, sz) : '0;
      rderr = ok_sz && (ba == rd_err_addr);
      exp_rd = ok_sz ? 1 : 0;
      exp_wr = (ok_sz && wr && !rderr) ? 1 : 0;
      exp_err = !ok_sz || rderr || (exp_wr == 1 && ba == wr_err_addr);
      exp_rdata = (ok_sz && !wr && !rderr) ? ((v >> bp) & 32'd1) : '0;
      exp_wdata = wd[0] ? (v | (32'd1 << bp)) : (v & ~(32'd1 << bp));
      rd_cnt = 0; wr_cnt = 0; busy_bad = 1'b0;

      @(negedge clk);
      s_req_valid = 1'b1; s_req_write = wr; s_req_addr = addr;
      s_req_size = sz; s_req_wdata = wd;
      guard = 0;
      while (!s_req_ready && guard < 2000) begin @(negedge clk); guard++; end
      @(negedge clk);
      s_req_valid = 1'b0; s_req_wdata = 32'hFFFF_FFFF;
      while (!s_rsp_valid && guard < 2000) begin
         if (s_req_ready) busy_bad = 1'b1;
         @(negedge clk); guard++;
      end
      check("R9", "watchdog on access", 32'(guard >= 2000), 0);
      for (int h = 0; h < rsp_hold; h++) begin
         @(negedge clk);
         check("R11", "response held under back-pressure", {30'b0, s_rsp_valid, s_rsp_err},
               {30'b0, 1'b1, exp_err});
      end
      if (s_req_ready) busy_bad = 1'b1;
      check("R9", "alias port busy until response", 32'(busy_bad), 0);
      check(wr ? "R6" : "R5", "response data", s_rsp_rdata, exp_rdata);
      check(rderr ? "R7" : (exp_err && ok_sz ? "R8" : "R3"), "response error", 32'(s_rsp_err), 32'(exp_err));
      s_rsp_ready = 1'b1;
      @(negedge clk);
      s_rsp_ready = 1'b0;
      check("R9", "response dropped after handshake", 32'(s_rsp_valid), 0);
      check(ok_sz ? "R1" : "R3", "backing read count", 32'(rd_cnt), 32'(exp_rd));
      check(rderr ? "R7" : "R6", "backing write count", 32'(wr_cnt), 32'(exp_wr));
      if (exp_rd == 1) begin
         check("R2", "backing read address", rd_addr_log, ba);
         check("R3", "backing read size", 32'(rd_size_log), 32'(sz));
      end
      if (exp_wr == 1) begin
         check("R6", "backing write address", wr_addr_log, ba);
         check("R3", "backing write size", 32'(wr_size_log), 32'(sz));
         check("R4", "merged write data", wr_data_log, exp_wdata);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: state during reset
      check("R10", "ready in reset", 32'(s_req_ready), 1);
      check("R10", "no backing request in reset", 32'(m_req_valid), 0);
      check("R10", "no alias response in reset", 32'(s_rsp_valid), 0);
      check("R10", "no backing response ready in reset", 32'(m_rsp_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5/R4: reads across sizes and positions
      access(0, ALIAS + 32'h0000, 2'd2, 0, "R5");
      access(0, ALIAS + 32'h007C, 2'd2, 0, "R4");
      access(0, ALIAS + 32'h001C, 2'd0, 0, "R4");
      access(0, ALIAS + 32'h0020, 2'd0, 0, "R1");
      access(0, ALIAS + 32'h003C, 2'd1, 0, "R4");
      access(0, ALIAS + 32'h0024, 2'd1, 0, "R4");
      // R2: alignment of a 4-byte access at byte offset 3
      access(0, ALIAS + 32'h0064, 2'd2, 0, "R2");
      // R1: last word of the window, and junk in upper alias bits
      access(0, ALIAS + 32'h01FF_FFFC, 2'd0, 0, "R1");
      access(0, 32'hFE00_0040, 2'd2, 0, "R1");
      access(0, 32'h0000_0044, 2'd1, 0, "R1");

      // R6: set and clear with noise in upper write bits
      access(1, ALIAS + 32'h0048, 2'd2, 32'h0000_0001, "R6");
      access(0, ALIAS + 32'h0048, 2'd2, 0, "R6");
      access(1, ALIAS + 32'h002C, 2'd0, 32'hFFFF_FFFE, "R6");
      access(0, ALIAS + 32'h002C, 2'd0, 0, "R6");
      access(1, ALIAS + 32'h1234, 2'd1, 32'h0000_0001, "R6");
      access(0, ALIAS + 32'h1234, 2'd0, 0, "R6");
      for (int i = 0; i < 32; i++)
         access(1, ALIAS + 32'h0800 + 32'(4 * i), 2'd2, (i % 3 == 0) ? 32'h1 : 32'hFFFF_FFF0, "R6");
      for (int i = 0; i < 32; i++)
         access(0, ALIAS + 32'h0800 + 32'(4 * i), 2'd2, 0, "R6");
      check("R6", "word after bitwise writes", fetch(BASE + 32'h40, 2'd2), 32'h4924_9249);

      // R3: illegal size code
      access(0, ALIAS + 32'h0010, 2'd3, 0, "R3");
      access(1, ALIAS + 32'h0010, 2'd3, 1, "R3");

      // R7: backing read error, for a read and for a write
      rd_err_addr = BASE + 32'h100;
      access(0, ALIAS + 32'h2000, 2'd2, 0, "R7");
      access(1, ALIAS + 32'h2004, 2'd2, 1, "R7");
      rd_err_addr = NO_ERR;
      access(0, ALIAS + 32'h2004, 2'd2, 0, "R7");

      // R8: backing write error passed through, memory untouched
      wr_err_addr = BASE + 32'h200;
      access(1, ALIAS + 32'h4000, 2'd2, 1, "R8");
      wr_err_addr = NO_ERR;
      access(0, ALIAS + 32'h4000, 2'd2, 0, "R8");

      // R9/R11: backing latency and alias back-pressure
      lat = 3; rsp_hold = 2;
      access(1, ALIAS + 32'h0104, 2'd0, 1, "R11");
      access(0, ALIAS + 32'h0104, 2'd0, 0, "R11");
      access(1, ALIAS + 32'h0108, 2'd1, 0, "R9");
      lat = 0; rsp_hold = 0;

      finished = 1'b1;
      summary();
   end

endmodule